// File: doc/BRIEF.md
# Processor Control Register File

This block holds the system control registers of a small processor model. Software reaches them through register-move style accesses: one 2-bit index selects a register, a write strobe stores the data word into it, and the read port returns the selected register in the same cycle. Hardware can also change the registers without software. A task-switch strobe sets the task-switched flag, and a page-fault strobe captures a 32-bit faulting linear address.

The mode register drives the core's mode lines: protected-mode enable, paging enable, coprocessor emulation, math-present and task-switched. A small decode check uses these lines to raise a coprocessor-unavailable request. Index 0 is the mode register. Index 1 is reserved. Index 2 holds the page-fault address. Index 3 holds the page-directory base. All ports are plain control and status pins. There is no valid/ready handshake, so the block never applies back-pressure: a write is accepted in the cycle its strobe is high.

Top module: `sysctl_regfile`

## Requirements
- R1: After reset, every index reads zero and all five mode outputs are low, so the core is in real-address mode with paging off.
- R2: A write to index 0 stores these bits: 0 protection enable, 1 math present, 2 emulate, 3 task switched, 4 extension type, 31 paging enable. The other bits read zero. The mode outputs follow the stored bits from the next cycle.
- R3: Index 1 always reads zero, and writes to it have no effect.
- R4: A write to index 2 stores all 32 bits, and a read returns them.
- R5: When a page-fault strobe arrives while the stored paging bit is set, index 2 holds the strobe's address from the next cycle. When the paging bit is clear, the strobe is ignored.
- R6: If a page-fault capture and a software write to index 2 fall in the same cycle, the captured address is the one stored.
- R7: A write to index 3 stores the data with bits 11..0 forced to zero.
- R8: A task-switch strobe sets the task-switched bit in the next cycle. This holds even when a software write to index 0 in the same cycle carries that bit as zero.
- R9: The coprocessor-unavailable request is high in the same cycle as a coprocessor-instruction decode if emulate or task-switched is set.
- R10: The coprocessor-unavailable request is high in the same cycle as a wait-instruction decode if both math-present and task-switched are set.
- R11: Reads are combinational: the read data follows the index in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| reg_idx_i | input | 2 | Register index for read and write |
| wr_en_i | input | 1 | Software write strobe |
| wr_data_i | input | 32 | Software write data |
| rd_data_o | output | 32 | Selected register contents |
| task_sw_i | input | 1 | Task-switch strobe |
| pf_i | input | 1 | Page-fault strobe |
| pf_addr_i | input | 32 | Faulting linear address |
| copro_op_i | input | 1 | Coprocessor instruction decoded |
| wait_op_i | input | 1 | Wait instruction decoded |
| prot_en_o | output | 1 | Protected-mode enable |
| paging_en_o | output | 1 | Paging enable |
| emulate_o | output | 1 | Coprocessor emulation |
| math_present_o | output | 1 | Math present |
| task_sw_o | output | 1 | Task-switched flag |
| copro_unavail_o | output | 1 | Coprocessor-unavailable request |

## Verification
Two pairs of functions can fall in the same cycle. In the first, a page-fault capture meets a software write to the fault-address register. The bench drives the page-fault strobe and a write to index 2 on the same clock edge while paging is on, then reads index 2 and expects the captured address, not the written one. In the second, a task-switch strobe meets a write to the mode register that clears the task-switched bit. The bench drives both together and expects the flag to come out set.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
  localparam int unsigned IDX_W = 2;
  localparam logic [IDX_W-1:0] IDX_MODE  = 2'd0;
  localparam logic [IDX_W-1:0] IDX_RSVD  = 2'd1;
  localparam logic [IDX_W-1:0] IDX_FAULT = 2'd2;
  localparam logic [IDX_W-1:0] IDX_DIR   = 2'd3;

  localparam int unsigned BIT_PE = 0;
  localparam int unsigned BIT_MP = 1;
  localparam int unsigned BIT_EM = 2;
  localparam int unsigned BIT_TS = 3;
  localparam int unsigned BIT_ET = 4;

  typedef struct packed {
    logic paging;
    logic ext_type;
    logic task_sw;
    logic emulate;
    logic math_pres;
    logic prot;
  } mode_t;
endpackage

// File: rtl/sysctl_mode_reg.sv
module sysctl_mode_reg
  import sysctl_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              task_sw_i,
  output mode_t             mode_o,
  output logic [DATA_W-1:0] word_o
);
  localparam int unsigned PG_BIT = DATA_W - 1;

  mode_t mode_q, mode_d;

  always_comb begin
    mode_d = mode_q;
    if (wr_i) begin
      mode_d.prot      = wdata_i[BIT_PE];
      mode_d.math_pres = wdata_i[BIT_MP];
      mode_d.emulate   = wdata_i[BIT_EM];
      mode_d.task_sw   = wdata_i[BIT_TS];
      mode_d.ext_type  = wdata_i[BIT_ET];
      mode_d.paging    = wdata_i[PG_BIT];
    end
    if (task_sw_i) mode_d.task_sw = 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) mode_q <= '0;
    else         mode_q <= mode_d;
  end

  always_comb begin
    word_o         = '0;
    word_o[BIT_PE] = mode_q.prot;
    word_o[BIT_MP] = mode_q.math_pres;
    word_o[BIT_EM] = mode_q.emulate;
    word_o[BIT_TS] = mode_q.task_sw;
    word_o[BIT_ET] = mode_q.ext_type;
    word_o[PG_BIT] = mode_q.paging;
  end

  assign mode_o = mode_q;
endmodule

// File: rtl/sysctl_addr_reg.sv
module sysctl_addr_reg #(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned ZERO_LSB = 0,
  parameter bit          HAS_CAP  = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              cap_i,
  input  logic [DATA_W-1:0] cap_data_i,
  output logic [DATA_W-1:0] q_o
);
  localparam logic [DATA_W-1:0] KEEP_MASK = {DATA_W{1'b1}} << ZERO_LSB;

  logic [DATA_W-1:0] q_q, q_d;

  generate
    if (HAS_CAP) begin : g_cap
      always_comb begin
        q_d = q_q;
        if (wr_i)  q_d = wdata_i & KEEP_MASK;
        if (cap_i) q_d = cap_data_i & KEEP_MASK;
      end
    end else begin : g_plain
      logic unused_cap;
      assign unused_cap = cap_i ^ (^cap_data_i);
      always_comb begin
        q_d = q_q;
        if (wr_i) q_d = wdata_i & KEEP_MASK;
      end
    end
  endgenerate

  always_ff @(posedge clk_i) begin
    if (!rst_ni) q_q <= '0;
    else         q_q <= q_d;
  end

  assign q_o = q_q;
endmodule

// File: rtl/sysctl_copro_check.sv
module sysctl_copro_check (
  input  logic copro_op_i,
  input  logic wait_op_i,
  input  logic emulate_i,
  input  logic math_pres_i,
  input  logic task_sw_i,
  output logic unavail_o
);
  logic copro_hit, wait_hit;

  assign copro_hit = copro_op_i & (emulate_i | task_sw_i);
  assign wait_hit  = wait_op_i & math_pres_i & task_sw_i;
  assign unavail_o = copro_hit | wait_hit;
endmodule

// File: rtl/sysctl_regfile.sv
module sysctl_regfile
  import sysctl_pkg::*;
#(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned PAGE_BITS = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        reg_idx_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              task_sw_i,
  input  logic              pf_i,
  input  logic [DATA_W-1:0] pf_addr_i,
  input  logic              copro_op_i,
  input  logic              wait_op_i,
  output logic              prot_en_o,
  output logic              paging_en_o,
  output logic              emulate_o,
  output logic              math_present_o,
  output logic              task_sw_o,
  output logic              copro_unavail_o
);
  mode_t             mode;
  logic [DATA_W-1:0] mode_word, fault_word, dir_word;
  logic              wr_mode, wr_fault, wr_dir, pf_cap;

  assign wr_mode  = wr_en_i && (reg_idx_i == IDX_MODE);
  assign wr_fault = wr_en_i && (reg_idx_i == IDX_FAULT);
  assign wr_dir   = wr_en_i && (reg_idx_i == IDX_DIR);
  assign pf_cap   = pf_i && mode.paging;

  sysctl_mode_reg #(.DATA_W(DATA_W)) u_mode (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (wr_mode),
    .wdata_i   (wr_data_i),
    .task_sw_i (task_sw_i),
    .mode_o    (mode),
    .word_o    (mode_word)
  );

  sysctl_addr_reg #(.DATA_W(DATA_W), .ZERO_LSB(0), .HAS_CAP(1'b1)) u_fault (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (wr_fault),
    .wdata_i    (wr_data_i),
    .cap_i      (pf_cap),
    .cap_data_i (pf_addr_i),
    .q_o        (fault_word)
  );

  sysctl_addr_reg #(.DATA_W(DATA_W), .ZERO_LSB(PAGE_BITS), .HAS_CAP(1'b0)) u_dir (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (wr_dir),
    .wdata_i    (wr_data_i),
    .cap_i      (1'b0),
    .cap_data_i ({DATA_W{1'b0}}),
    .q_o        (dir_word)
  );

  sysctl_copro_check u_copro (
    .copro_op_i  (copro_op_i),
    .wait_op_i   (wait_op_i),
    .emulate_i   (mode.emulate),
    .math_pres_i (mode.math_pres),
    .task_sw_i   (mode.task_sw),
    .unavail_o   (copro_unavail_o)
  );

  always_comb begin
    unique case (reg_idx_i)
      IDX_MODE:  rd_data_o = mode_word;
      IDX_RSVD:  rd_data_o = '0;
      IDX_FAULT: rd_data_o = fault_word;
      default:   rd_data_o = dir_word;
    endcase
  end

  assign prot_en_o      = mode.prot;
  assign paging_en_o    = mode.paging;
  assign emulate_o      = mode.emulate;
  assign math_present_o = mode.math_pres;
  assign task_sw_o      = mode.task_sw;
endmodule

// File: rtl/sysctl_regfile_chk.sv
module sysctl_regfile_chk #(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned PAGE_BITS = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [1:0]        reg_idx_i,
  input logic              wr_en_i,
  input logic [DATA_W-1:0] rd_data_o,
  input logic              task_sw_i,
  input logic              pf_i,
  input logic [DATA_W-1:0] pf_addr_i,
  input logic              copro_op_i,
  input logic              wait_op_i,
  input logic              paging_en_o,
  input logic              emulate_o,
  input logic              math_present_o,
  input logic              task_sw_o,
  input logic              copro_unavail_o
);
  assert_ts_set_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    task_sw_i |=> task_sw_o);

  assert_pf_capture_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pf_i && paging_en_o && reg_idx_i == 2'd2) |=>
      (reg_idx_i != 2'd2 || rd_data_o == $past(pf_addr_i)));

  assert_rsvd_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_idx_i == 2'd1) |-> (rd_data_o == '0));

  assert_dir_align_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_idx_i == 2'd3) |-> (rd_data_o[PAGE_BITS-1:0] == '0));

  assert_mode_rsvd_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_idx_i == 2'd0) |-> (rd_data_o[DATA_W-2:5] == '0));

  assert_copro_req_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (copro_op_i && (emulate_o || task_sw_o)) |-> copro_unavail_o);

  assert_wait_req_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wait_op_i && math_present_o && task_sw_o) |-> copro_unavail_o);

  assert_no_spurious_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!copro_op_i && !wait_op_i) |-> !copro_unavail_o);

  logic unused_wr;
  assign unused_wr = wr_en_i;
endmodule

bind sysctl_regfile sysctl_regfile_chk #(.DATA_W(DATA_W), .PAGE_BITS(PAGE_BITS)) chk_i (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .reg_idx_i       (reg_idx_i),
  .wr_en_i         (wr_en_i),
  .rd_data_o       (rd_data_o),
  .task_sw_i       (task_sw_i),
  .pf_i            (pf_i),
  .pf_addr_i       (pf_addr_i),
  .copro_op_i      (copro_op_i),
  .wait_op_i       (wait_op_i),
  .paging_en_o     (paging_en_o),
  .emulate_o       (emulate_o),
  .math_present_o  (math_present_o),
  .task_sw_o       (task_sw_o),
  .copro_unavail_o (copro_unavail_o)
);

// File: tb/sysctl_regfile_tb_top.sv
`timescale 1ns/1ps
module sysctl_regfile_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  reg_idx = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        task_sw = 1'b0;
  logic        pf = 1'b0;
  logic [31:0] pf_addr = '0;
  logic        copro_op = 1'b0;
  logic        wait_op = 1'b0;
  logic        prot_en, paging_en, emulate, math_present, task_sw_flag, copro_unavail;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  sysctl_regfile dut_i (
    .clk_i(clk), .rst_ni(rst_n), .reg_idx_i(reg_idx), .wr_en_i(wr_en),
    .wr_data_i(wr_data), .rd_data_o(rd_data), .task_sw_i(task_sw),
    .pf_i(pf), .pf_addr_i(pf_addr), .copro_op_i(copro_op), .wait_op_i(wait_op),
    .prot_en_o(prot_en), .paging_en_o(paging_en), .emulate_o(emulate),
    .math_present_o(math_present), .task_sw_o(task_sw_flag),
    .copro_unavail_o(copro_unavail)
  );

  localparam int NV = 8;
  localparam logic [1:0]  V_IDX [NV] = '{2'd0, 2'd0, 2'd1, 2'd2, 2'd3, 2'd3, 2'd2, 2'd0};
  localparam logic [31:0] V_WD  [NV] = '{32'hFFFF_FFFF, 32'h0000_0015, 32'hFFFF_FFFF,
                                         32'hDEAD_BEEF, 32'h1234_5678, 32'hFFFF_FFFF,
                                         32'h0000_0001, 32'h0000_0000};
  localparam logic [31:0] V_EXP [NV] = '{32'h8000_001F, 32'h0000_0015, 32'h0000_0000,
                                         32'hDEAD_BEEF, 32'h1234_5000, 32'hFFFF_F000,
                                         32'h0000_0001, 32'h0000_0000};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] idx, input logic [31:0] d);
    @(negedge clk);
    reg_idx = idx; wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_check(input string req, input logic [1:0] idx, input logic [31:0] exp);
    reg_idx = idx;
    #1;
    check(req, rd_data, exp);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    for (int i = 0; i < 4; i++) rd_check("R1", 2'(i), 32'h0);
    check("R1 modes", {27'h0, prot_en, paging_en, emulate, math_present, task_sw_flag}, 32'h0);

    // R2 R3 R4 R7 R11 vector table
    for (int v = 0; v < NV; v++) begin
      wr(V_IDX[v], V_WD[v]);
      rd_check("R2/R3/R4/R7 R11", V_IDX[v], V_EXP[v]);
    end

    // R2 mode outputs
    wr(2'd0, 32'h8000_0007);
    #1;
    check("R2 modes", {27'h0, prot_en, paging_en, emulate, math_present, task_sw_flag}, 32'h1E);

    // R9 emulate path
    copro_op = 1'b1; #1;
    check("R9 emulate", {31'h0, copro_unavail}, 32'h1);
    wr(2'd0, 32'h8000_0001);
    #1;
    check("R9 clear", {31'h0, copro_unavail}, 32'h0);
    copro_op = 1'b0;

    // R8 task switch strobe
    @(negedge clk); task_sw = 1'b1;
    @(negedge clk); task_sw = 1'b0;
    check("R8 strobe", {31'h0, task_sw_flag}, 32'h1);
    copro_op = 1'b1; #1;
    check("R9 ts", {31'h0, copro_unavail}, 32'h1);
    copro_op = 1'b0;

    // R10 wait check
    wait_op = 1'b1; #1;
    check("R10 no mp", {31'h0, copro_unavail}, 32'h0);
    wait_op = 1'b0;
    wr(2'd0, 32'h8000_000B);
    wait_op = 1'b1; #1;
    check("R10 mp ts", {31'h0, copro_unavail}, 32'h1);
    wait_op = 1'b0;

    // R8 collision with software clear
    @(negedge clk);
    reg_idx = 2'd0; wr_en = 1'b1; wr_data = 32'h8000_0001; task_sw = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; task_sw = 1'b0;
    rd_check("R8 collision", 2'd0, 32'h8000_0009);

    // R5 capture with paging on
    @(negedge clk); pf = 1'b1; pf_addr = 32'hCAFE_1234;
    @(negedge clk); pf = 1'b0;
    rd_check("R5 capture", 2'd2, 32'hCAFE_1234);

    // R6 collision: capture beats software write
    @(negedge clk);
    reg_idx = 2'd2; wr_en = 1'b1; wr_data = 32'h5555_5555;
    pf = 1'b1; pf_addr = 32'hA5A5_A000;
    @(negedge clk);
    wr_en = 1'b0; pf = 1'b0;
    rd_check("R6 collision", 2'd2, 32'hA5A5_A000);

    // R5 ignored with paging off
    wr(2'd0, 32'h0000_0000);
    @(negedge clk); pf = 1'b1; pf_addr = 32'h1111_1111;
    @(negedge clk); pf = 1'b0;
    rd_check("R5 paging off", 2'd2, 32'hA5A5_A000);

    // R3 write to reserved leaves others intact
    wr(2'd1, 32'hFFFF_FFFF);
    rd_check("R3 rsvd", 2'd1, 32'h0);
    rd_check("R3 mode intact", 2'd0, 32'h0);

    // R1 reset clears everything again
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    rd_check("R1 fault", 2'd2, 32'h0);
    rd_check("R1 dir", 2'd3, 32'h0);

    finish_run();
  end
endmodule